// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Receive FIFO and Status Flags

This block recovers characters from a single asynchronous serial line and queues them for software. Each frame opens with a low start bit, carries eight data bits least significant bit first, may carry a parity bit, and closes with one high stop bit. The line is oversampled sixteen times per bit. A start is accepted only if the line is still low at the start bit's midpoint. Every later bit is sampled at the middle of its period.

Characters that pass the stop and parity checks are written into a 16-entry FIFO. Four sticky flags report status: data-full, framing error, parity error and overrun. A flag is cleared only by a two-step handshake. Software first reads the flag register, which arms every bit that was 1. It then writes the register, and each armed bit written as 0 is cleared. Two interrupt requests are produced. One is raised for received data. The other is raised for any receive error.

Top module: `async_rx_unit`

## Requirements
- R1: After reset, `flags_o` is 0, `count_o` is 0, and both interrupt outputs are low.
- R2: Each bit lasts 16 ticks. D0 is the first data bit after the start bit. Good characters are read from `rdata_o` in arrival order. Pulsing `pop_i` for one cycle removes the head entry.
- R3: A character is good when its stop bit is 1 and, if parity is enabled, its parity matches. Storing a good character sets the data-full flag `flags_o[0]`. `rx_irq_o` is high exactly while `flags_o[0]` is 1.
- R4: Each flag bit has a clear path with two steps:
  - A one-cycle `flag_rd_i` arms every flag bit that is 1 at that moment.
  - A one-cycle `flag_wr_i` then clears each armed bit whose `flag_wdata_i` bit is 0, and disarms all bits.
  - A write with no preceding read clears nothing. Writing 1 to a bit clears nothing.
- R5: A stop bit sampled as 0 sets the framing-error flag `flags_o[1]`, and the character is not stored.
- R6: `par_mode_i` selects the parity mode:
  - 0 or 3: no parity bit in the frame.
  - 1 (even): the eight data bits plus the parity bit hold an even number of ones.
  - 2 (odd): the eight data bits plus the parity bit hold an odd number of ones.
  - A mismatch sets the parity-error flag `flags_o[2]`, and the character is not stored.
- R7: The FIFO holds 16 characters. A good character that arrives while it is full is dropped, the overrun flag `flags_o[3]` is set, and the stored 16 characters are kept unchanged.
- R8: A low pulse that has ended before the start bit's midpoint sample is ignored. Nothing is stored and no flag changes.
- R9: `err_irq_o` is high exactly while any of `flags_o[3:1]` is 1. It falls once those flags are cleared.
- R10: `pop_i` while the FIFO is empty has no effect.
- R11: One tick lasts `div_i` clock cycles, with 0 treated as 1. A bit therefore lasts 16×`div_i` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| div_i | input | 16 | Clock cycles per oversampling tick |
| par_mode_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| pop_i | input | 1 | Removes the FIFO head entry |
| rdata_o | output | 8 | FIFO head character |
| count_o | output | 5 | Number of characters in the FIFO |
| flag_rd_i | input | 1 | Flag register read strobe; arms the bits that are set |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 4 | Write data; a 0 clears the matching armed flag |
| flags_o | output | 4 | {overrun, parity error, framing error, data full} |
| rx_irq_o | output | 1 | Data-ready interrupt request |
| err_irq_o | output | 1 | Receive-error interrupt request |

## Verification
The assertions check four things on every cycle:
- the FIFO count never exceeds its depth and moves by at most one per cycle;
- every store is accompanied by the data-full flag;
- an overrun is raised only from a full FIFO, and a framing error never adds an entry;
- a flag falls only in the cycle after a flag write.

Other properties need whole frames and are covered only by the bench's scenarios. These are the bit order, the parity verdicts in each mode, glitch rejection, the read-then-write clear rule, and the scaling of bit timing with the divisor.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  localparam int FLAG_FULL = 0;
  localparam int FLAG_FER  = 1;
  localparam int FLAG_PER  = 2;
  localparam int FLAG_OVR  = 3;
  localparam int FLAG_W    = 4;
endpackage

// File: rtl/async_rx_tick.sv
module async_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  assign last   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, div_i};
  assign tick_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/async_rx_sampler.sv
module async_rx_sampler
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        par_mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fer_o,
  output logic              per_o
);
  localparam int OS_W  = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OS_W-1:0]  OS_MID  = OS_W'(OSR/2 - 1);
  localparam logic [OS_W-1:0]  OS_LAST = OS_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  logic              rx;
  rx_state_e         st_q;
  logic [OS_W-1:0]   os_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              acc_q;
  logic              par_on;

  assign rx     = sync_q[1];
  assign par_on = (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      os_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      acc_q  <= 1'b0;
      done_o <= 1'b0;
      fer_o  <= 1'b0;
      per_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: if (!rx) begin
            st_q <= ST_START;
            os_q <= '0;
          end
          ST_START: begin
            if (os_q == OS_MID) begin
              os_q <= '0;
              // still low at midpoint: genuine start, else glitch
              if (!rx) begin
                st_q  <= ST_DATA;
                bit_q <= '0;
                acc_q <= 1'b0;
                per_o <= 1'b0;
              end else begin
                st_q <= ST_IDLE;
              end
            end else os_q <= os_q + 1'b1;
          end
          ST_DATA: begin
            if (os_q == OS_LAST) begin
              os_q  <= '0;
              sh_q  <= {rx, sh_q[DATA_W-1:1]};
              acc_q <= acc_q ^ rx;
              bit_q <= bit_q + 1'b1;
              if (bit_q == BIT_END) st_q <= par_on ? ST_PAR : ST_STOP;
            end else os_q <= os_q + 1'b1;
          end
          ST_PAR: begin
            if (os_q == OS_LAST) begin
              os_q  <= '0;
              per_o <= acc_q ^ rx ^ (par_mode_i == PAR_ODD);
              st_q  <= ST_STOP;
            end else os_q <= os_q + 1'b1;
          end
          ST_STOP: begin
            if (os_q == OS_LAST) begin
              os_q   <= '0;
              fer_o  <= !rx;
              done_o <= 1'b1;
              st_q   <= ST_IDLE;
            end else os_q <= os_q + 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     pop_i,
  output logic [DATA_W-1:0]        head_o,
  output logic [$clog2(DEPTH):0]   count_o,
  output logic                     full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic              do_push, do_pop;

  assign full_o  = count_o == (AW+1)'(DEPTH);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (count_o != '0);
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit
  import async_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OSR    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rxd_i,
  input  logic [DIV_W-1:0]       div_i,
  input  logic [1:0]             par_mode_i,
  input  logic                   pop_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [$clog2(DEPTH):0] count_o,
  input  logic                   flag_rd_i,
  input  logic                   flag_wr_i,
  input  logic [FLAG_W-1:0]      flag_wdata_i,
  output logic [FLAG_W-1:0]      flags_o,
  output logic                   rx_irq_o,
  output logic                   err_irq_o
);
  logic              tick, done, fer, per, full, good;
  logic [DATA_W-1:0] char;
  logic [FLAG_W-1:0] set, clr, armed_q;

  async_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i, .tick_o(tick)
  );

  async_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_smp (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i, .par_mode_i,
    .done_o(done), .data_o(char), .fer_o(fer), .per_o(per)
  );

  assign good = done && !fer && !per;

  async_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i, .rst_ni, .push_i(good), .wdata_i(char), .pop_i,
    .head_o(rdata_o), .count_o, .full_o(full)
  );

  always_comb begin
    set            = '0;
    set[FLAG_FULL] = good && !full;
    set[FLAG_FER]  = done && fer;
    set[FLAG_PER]  = done && per;
    set[FLAG_OVR]  = good && full;
    clr            = flag_wr_i ? (armed_q & ~flag_wdata_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      armed_q <= '0;
    end else begin
      flags_o <= (flags_o & ~clr) | set;  // a new event wins over a clear
      if (flag_rd_i)      armed_q <= flags_o;
      else if (flag_wr_i) armed_q <= '0;
    end
  end

  assign rx_irq_o  = flags_o[FLAG_FULL];
  assign err_irq_o = |flags_o[FLAG_OVR:FLAG_FER];
endmodule

// File: rtl/async_rx_unit_chk.sv
module async_rx_unit_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   flag_wr_i,
  input logic [$clog2(DEPTH):0] count_o,
  input logic [3:0]             flags_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R7

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1) ||
    (count_o + 1'b1 == $past(count_o))); // R10

  AST_STORE_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == $past(count_o) + 1'b1) |-> flags_o[0]); // R3

  AST_OVR_FROM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[3]) |-> ($past(count_o) == CW'(DEPTH))); // R7

  AST_FER_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[1]) |-> (count_o <= $past(count_o))); // R5

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flags_o) & ~flags_o) != 4'd0 |-> $past(flag_wr_i)); // R4
endmodule

bind async_rx_unit async_rx_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flag_wr_i(flag_wr_i),
  .count_o(count_o), .flags_o(flags_o)
);

// File: tb/async_rx_unit_tb.sv
module async_rx_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [15:0] div = 16'd1;
  logic [1:0] pmode = 2'd0;
  logic       pop = 1'b0, frd = 1'b0, fwr = 1'b0;
  logic [3:0] fwdata = 4'hF;
  logic [7:0] rdata;
  logic [4:0] count;
  logic [3:0] flags;
  logic       rx_irq, err_irq;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic [3:0] exp_f = 4'h0, exp_arm = 4'h0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  async_rx_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .div_i(div), .par_mode_i(pmode),
    .pop_i(pop), .rdata_o(rdata), .count_o(count), .flag_rd_i(frd),
    .flag_wr_i(fwr), .flag_wdata_i(fwdata), .flags_o(flags),
    .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-clock comparison against the behavioural model
  always begin
    @(posedge clk);
    #3;
    if (cmp_en && rst_n) begin
      check("R2 count", int'(count), q.size());
      if (q.size() != 0) check("R2 head", int'(rdata), int'(q[0]));
      check("R4 flags", int'(flags), int'(exp_f));
      check("R3 rx_irq", int'(rx_irq), int'(exp_f[0]));
      check("R9 err_irq", int'(err_irq), int'(|exp_f[3:1]));
    end
  end

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (16 * ((div == 0) ? 1 : int'(div))) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic p;
    cmp_en = 1'b0;
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i]);
    if (pmode == 2'd1 || pmode == 2'd2) begin
      p = (^d) ^ (pmode == 2'd2) ^ bad_par;
      hold_bit(p);
    end
    hold_bit(!bad_stop);
    rxd = 1'b1;
    if (bad_stop) exp_f[1] = 1'b1;
    else if (bad_par) exp_f[2] = 1'b1;
    else if (q.size() < 16) begin q.push_back(d); exp_f[0] = 1'b1; end
    else exp_f[3] = 1'b1;
    hold_bit(1'b1);
    cmp_en = 1'b1;
  endtask

  task automatic flag_read();
    frd = 1'b1; exp_arm = exp_f;
    @(negedge clk); frd = 1'b0;
  endtask

  task automatic flag_write(input logic [3:0] w);
    fwr = 1'b1; fwdata = w;
    exp_f = exp_f & ~(exp_arm & ~w); exp_arm = 4'h0;
    @(negedge clk); fwr = 1'b0; fwdata = 4'hF;
  endtask

  task automatic pop_one(input string req);
    check(req, int'(rdata), (q.size() != 0) ? int'(q[0]) : int'(rdata));
    pop = 1'b1;
    if (q.size() != 0) void'(q.pop_front());
    @(negedge clk); pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags", int'(flags), 0);
    check("R1 count", int'(count), 0);
    check("R1 irqs", int'({rx_irq, err_irq}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;

    // R2 bit order and ordering, R3 data-full
    send(8'hA5, 0, 0);
    send(8'h3C, 0, 0);
    check("R2 count two", int'(count), 2);
    check("R2 head lsb first", int'(rdata), 8'hA5);
    check("R3 rx_irq set", int'(rx_irq), 1);

    // R4 clear handshake
    flag_write(4'h0);
    check("R4 write without read", int'(flags[0]), 1);
    flag_read();
    flag_write(4'hF);
    check("R4 write one", int'(flags[0]), 1);
    pop_one("R2 pop first");
    pop_one("R2 pop second");
    flag_read();
    flag_write(4'hE);
    check("R4 cleared", int'(flags[0]), 0);
    check("R3 rx_irq low", int'(rx_irq), 0);

    // R10 pop on empty
    pop_one("R10 pop empty");
    check("R10 count stays", int'(count), 0);

    // R6 parity modes
    pmode = 2'd1; send(8'h96, 0, 0);
    pmode = 2'd2; send(8'h07, 0, 0);
    check("R6 good parity stored", int'(count), 2);
    pmode = 2'd1; send(8'h55, 1, 0);
    check("R6 parity error flag", int'(flags[2]), 1);
    check("R6 not stored", int'(count), 2);
    pmode = 2'd3; send(8'hC3, 0, 0);
    check("R6 mode3 no parity", int'(count), 3);
    pmode = 2'd0;
    pop_one("R6 even char"); pop_one("R6 odd char"); pop_one("R6 none char");

    // R5 framing error
    send(8'hFF, 0, 1);
    check("R5 fer set", int'(flags[1]), 1);
    check("R5 not stored", int'(count), 0);
    check("R9 err irq high", int'(err_irq), 1);
    flag_read();
    flag_write(4'h0);
    check("R9 err irq low", int'(err_irq), 0);

    // R8 glitch
    cmp_en = 1'b0;
    rxd = 1'b0; repeat (3) @(negedge clk);
    rxd = 1'b1; repeat (40) @(negedge clk);
    cmp_en = 1'b1;
    @(negedge clk);
    check("R8 glitch ignored", int'(count), 0);
    check("R8 flags unchanged", int'(flags), 0);

    // R11 divisor scaling
    div = 16'd3;
    send(8'h5A, 0, 0);
    check("R11 div3 char", int'(rdata), 8'h5A);
    pop_one("R11 pop");
    div = 16'd0;
    send(8'h81, 0, 0);
    check("R11 div0 char", int'(rdata), 8'h81);
    pop_one("R11 pop div0");
    div = 16'd1;

    // R7 overflow
    for (int i = 0; i < 16; i++) send(8'(i * 17 + 1), 0, 0);
    check("R7 full", int'(count), 16);
    send(8'hEE, 0, 0);
    check("R7 overrun flag", int'(flags[3]), 1);
    check("R7 count kept", int'(count), 16);
    for (int i = 0; i < 16; i++) pop_one("R7 order kept");
    flag_read();
    flag_write(4'h0);
    check("R9 all cleared", int'({err_irq, flags}), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule